// File: doc/BRIEF.md
# Pipelined Monobit Randomness Monitor

The monitor watches a stream of wide data words from a generator that is meant to look random. Over a fixed window of valid words it counts the one bits and, once the window closes, checks that the total lies strictly inside an acceptance band supplied on two bound inputs. The verdict is held in a registered pass flag. A single-cycle window-done strobe marks the cycle in which that flag is refreshed. Nothing downstream waits on the result, so the block is pipelined deeply and no path in it limits the clock.

A word enters a register stage. It is then split into 32-bit slices, and each slice is counted by a two-stage population counter. A pipelined adder tree reduces the slice counts to one per-word sum, and a window accumulator adds that sum to a running total. A final range stage compares the closed total against the bounds. With the default parameters (128-bit words, 256-word windows) a window holds 32,768 bits. A typical band is the expected count of 16,384 widened by 466 on each side. The package offers that band as a helper.

Top module: `monobit_monitor`

## Requirements
- R1: During and right after reset, `pass` reads 1 and `win_done` reads 0. Reset clears the window total and the word count, so the first window after reset counts only words presented after reset is released.
- R2: `win_done` is a one-cycle pulse. It fires exactly once for each 256 valid words.
- R3: At each window close, `pass` becomes 1 if and only if `bound_lo` < total < `bound_hi`. The comparison is strict and unsigned. The total is the number of one bits in the window's valid words.
- R4: A word presented with `in_valid` = 0 adds nothing to the total and does not advance the window.
- R5: `pass` and `win_done` update on the 8th rising edge, counting as the first the edge that samples the window's 256th valid word.
- R6: `pass` changes only in a cycle where `win_done` is 1, and holds its value at all other times.
- R7: An all-ones window totals 32,768 without overflow. With bounds 32,767 and 32,769 it passes.
- R8: Windows may follow each other with no gap. The first valid word after a window's last word belongs to the next window, and that window's total starts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_data | input | 128 | Data word under test |
| in_valid | input | 1 | Marks `in_data` as a word to count |
| bound_lo | input | 16 | Exclusive lower limit of the acceptance band |
| bound_hi | input | 16 | Exclusive upper limit of the acceptance band |
| pass | output | 1 | Verdict of the most recently closed window |
| win_done | output | 1 | One-cycle strobe when `pass` is refreshed |

## Verification
The bench places the bounds exactly on, one below and one above a known total. A design that used a non-strict comparison would then pass a window whose total equals a bound, and a design with an off-by-one total would fail an exact band. All-ones windows with a tight band around 32,768 expose an accumulator one bit too narrow, which would wrap to zero and fail. Windows laced with invalid all-ones words, windows sent back to back, and a reset in the middle of a window catch three further faults: a counter that advances on invalid words (early strobe and a wrong total), a total that leaks across a window boundary, and state that survives reset. Every strobe is also checked for the exact latency, and the flag is checked for stability between strobes.

// File: rtl/monobit_pkg.sv
// Package: shared defaults and helpers for the monobit monitor.
// Assumes: callers pass a word width and a log2 window length that are
// consistent with the monitor instance they describe.
package monobit_pkg;

    localparam int DEF_DATA_W    = 128;
    localparam int DEF_SLICE_W   = 32;
    localparam int DEF_GRP_W     = 8;
    localparam int DEF_WIN_LOG2  = 8;
    localparam int DEF_HALF_BAND = 466;

    // Number of bits covered by one window.
    function automatic int window_bits(input int data_w, input int win_log2);
        return data_w << win_log2;
    endfunction

    // Lower limit of a symmetric band around the expected count.
    function automatic int band_lo(input int data_w, input int win_log2, input int half);
        return (window_bits(data_w, win_log2) / 2) - half;
    endfunction

    // Upper limit of a symmetric band around the expected count.
    function automatic int band_hi(input int data_w, input int win_log2, input int half);
        return (window_bits(data_w, win_log2) / 2) + half;
    endfunction

endpackage

// File: rtl/slice_popcount.sv
// Module: slice_popcount
// Counts the one bits of one slice in two register stages. Stage one
// counts small groups of bits; stage two sums the group counts.
// Assumes: SLICE_W is a multiple of GRP_W. Pure datapath with no reset;
// the caller tracks validity alongside.
module slice_popcount #(
    parameter  int SLICE_W = 32,
    parameter  int GRP_W   = 8,
    localparam int NGRP    = SLICE_W / GRP_W,
    localparam int GRP_CW  = $clog2(GRP_W + 1),
    localparam int CNT_W   = $clog2(SLICE_W + 1)
) (
    input  logic               clk,
    input  logic [SLICE_W-1:0] bits,
    output logic [CNT_W-1:0]   count
);

    logic [NGRP-1:0][GRP_CW-1:0] grp_c;
    logic [NGRP-1:0][GRP_CW-1:0] grp_q;
    logic [CNT_W-1:0]            sum_c;

    // Count ones within each group of GRP_W bits.
    always_comb begin
        for (int g = 0; g < NGRP; g++) begin
            grp_c[g] = '0;
            for (int b = 0; b < GRP_W; b++) begin
                grp_c[g] = grp_c[g] + GRP_CW'(bits[g*GRP_W + b]);
            end
        end
    end

    // First stage: hold the group counts.
    always_ff @(posedge clk) begin
        grp_q <= grp_c;
    end

    // Add the group counts into the slice count.
    always_comb begin
        sum_c = '0;
        for (int g = 0; g < NGRP; g++) begin
            sum_c = sum_c + CNT_W'(grp_q[g]);
        end
    end

    // Second stage: hold the slice count.
    always_ff @(posedge clk) begin
        count <= sum_c;
    end

endmodule

// File: rtl/count_tree.sv
// Module: count_tree
// Pipelined pairwise adder tree: one register level per halving, plus an
// output register. Latency is $clog2(NUM_IN)+1 cycles.
// Assumes: NUM_IN is a power of two and at least 2. The valid bit travels
// with the data and is the only state that is reset.
module count_tree #(
    parameter  int NUM_IN = 4,
    parameter  int IN_W   = 6,
    localparam int LV     = $clog2(NUM_IN),
    localparam int OUT_W  = IN_W + LV
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_IN-1:0][IN_W-1:0]  in_cnt,
    input  logic                         in_vld,
    output logic [OUT_W-1:0]             sum,
    output logic                         out_vld
);

    logic [NUM_IN-1:0][OUT_W-1:0] node_q [LV];
    logic [LV:0]                  vld_sr;

    // Each level adds neighbouring pairs of the level below.
    always_ff @(posedge clk) begin
        for (int l = 0; l < LV; l++) begin
            for (int j = 0; j < NUM_IN; j++) begin
                if (j < (NUM_IN >> (l + 1))) begin
                    if (l == 0) begin
                        node_q[l][j] <= OUT_W'(in_cnt[2*j]) + OUT_W'(in_cnt[2*j+1]);
                    end else begin
                        node_q[l][j] <= node_q[l-1][2*j] + node_q[l-1][2*j+1];
                    end
                end else begin
                    node_q[l][j] <= '0;
                end
            end
        end
    end

    // Output register for the root sum.
    always_ff @(posedge clk) begin
        sum <= node_q[LV-1][0];
    end

    // Carry the valid bit alongside the tree levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_sr <= '0;
        end else begin
            vld_sr <= {vld_sr[LV-1:0], in_vld};
        end
    end

    assign out_vld = vld_sr[LV];

endmodule

// File: rtl/win_accum.sv
// Module: win_accum
// Adds per-word sums into a window total and counts valid words modulo
// 2**WIN_LOG2. On the last word of a window it presents the closed total
// for one cycle and restarts from zero.
// Assumes: ACC_W holds the largest possible window total.
module win_accum #(
    parameter int IN_W     = 8,
    parameter int ACC_W    = 16,
    parameter int WIN_LOG2 = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  word_sum,
    input  logic             word_vld,
    output logic [ACC_W-1:0] total,
    output logic             total_vld
);

    logic [ACC_W-1:0]    acc_q;
    logic [WIN_LOG2-1:0] word_cnt_q;
    logic [ACC_W-1:0]    acc_next;

    assign acc_next = acc_q + ACC_W'(word_sum);

    // Accumulate valid words and close the window on the count wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            word_cnt_q <= '0;
            total      <= '0;
            total_vld  <= 1'b0;
        end else begin
            total_vld <= 1'b0;
            if (word_vld) begin
                word_cnt_q <= word_cnt_q + 1'b1;
                if (&word_cnt_q) begin
                    total     <= acc_next;
                    total_vld <= 1'b1;
                    acc_q     <= '0;
                end else begin
                    acc_q <= acc_next;
                end
            end
        end
    end

endmodule

// File: rtl/range_gate.sv
// Module: range_gate
// Registers the verdict of a closed window: pass when the total lies
// strictly between the two bounds. The flag loads only when a total is
// presented; the done strobe marks that cycle.
// Assumes: bounds are stable around the window close.
module range_gate #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] total,
    input  logic             total_vld,
    input  logic [ACC_W-1:0] lo,
    input  logic [ACC_W-1:0] hi,
    output logic             pass,
    output logic             done
);

    // Load the verdict at window close; otherwise hold it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass <= 1'b1;
            done <= 1'b0;
        end else begin
            done <= total_vld;
            if (total_vld) begin
                pass <= (total > lo) && (total < hi);
            end
        end
    end

endmodule

// File: rtl/monobit_monitor.sv
// Module: monobit_monitor (top)
// Streaming ones-count monitor: input register, per-slice two-stage
// population counters, pipelined adder tree, window accumulator and
// registered range check.
// Assumes: DATA_W is a power-of-two multiple of SLICE_W; the result is
// latency tolerant, so every stage is registered.
module monobit_monitor #(
    parameter  int DATA_W   = monobit_pkg::DEF_DATA_W,
    parameter  int SLICE_W  = monobit_pkg::DEF_SLICE_W,
    parameter  int GRP_W    = monobit_pkg::DEF_GRP_W,
    parameter  int WIN_LOG2 = monobit_pkg::DEF_WIN_LOG2,
    localparam int NSLICE   = DATA_W / SLICE_W,
    localparam int SLICE_CW = $clog2(SLICE_W + 1),
    localparam int TREE_LV  = $clog2(NSLICE),
    localparam int SUM_W    = SLICE_CW + TREE_LV,
    localparam int ACC_W    = $clog2(monobit_pkg::window_bits(DATA_W, WIN_LOG2) + 1),
    localparam int PIPE_LAT = 1 + 2 + (TREE_LV + 1) + 1 + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic [ACC_W-1:0]  bound_lo,
    input  logic [ACC_W-1:0]  bound_hi,
    output logic              pass,
    output logic              win_done
);

    logic [DATA_W-1:0]                 data_q;
    logic                              vld_q;
    logic [1:0]                        vld_pop;
    logic [NSLICE-1:0][SLICE_CW-1:0]   slice_cnt;
    logic [SUM_W-1:0]                  word_sum;
    logic                              word_vld;
    logic [ACC_W-1:0]                  win_total;
    logic                              win_total_vld;

    // Input stage: hold data and its valid bit.
    always_ff @(posedge clk) begin
        data_q <= in_data;
        if (!rst_n) begin
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
        end
    end

    // One population counter per slice.
    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        slice_popcount #(
            .SLICE_W(SLICE_W),
            .GRP_W  (GRP_W)
        ) u_pop (
            .clk  (clk),
            .bits (data_q[s*SLICE_W +: SLICE_W]),
            .count(slice_cnt[s])
        );
    end

    // Valid bit across the two population-count stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_pop <= '0;
        end else begin
            vld_pop <= {vld_pop[0], vld_q};
        end
    end

    count_tree #(
        .NUM_IN(NSLICE),
        .IN_W  (SLICE_CW)
    ) u_tree (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_cnt (slice_cnt),
        .in_vld (vld_pop[1]),
        .sum    (word_sum),
        .out_vld(word_vld)
    );

    win_accum #(
        .IN_W    (SUM_W),
        .ACC_W   (ACC_W),
        .WIN_LOG2(WIN_LOG2)
    ) u_acc (
        .clk      (clk),
        .rst_n    (rst_n),
        .word_sum (word_sum),
        .word_vld (word_vld),
        .total    (win_total),
        .total_vld(win_total_vld)
    );

    range_gate #(
        .ACC_W(ACC_W)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .total    (win_total),
        .total_vld(win_total_vld),
        .lo       (bound_lo),
        .hi       (bound_hi),
        .pass     (pass),
        .done     (win_done)
    );

endmodule

// File: rtl/monobit_monitor_chk.sv
// Module: monobit_monitor_chk
// Port-level checker: tracks valid words itself and predicts when each
// window strobe must appear; checks reset state, pulse width and flag
// stability.
// Assumes: LAT equals the top's pipeline latency.
module monobit_monitor_chk #(
    parameter int WIN_LOG2 = 8,
    parameter int LAT      = 8
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic pass,
    input logic win_done
);

    logic [WIN_LOG2-1:0] seen_q;
    logic [LAT-1:0]      due_q;

    // Count valid words and delay each window close by LAT cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
            due_q  <= '0;
        end else begin
            if (in_valid) begin
                seen_q <= seen_q + 1'b1;
            end
            due_q <= {due_q[LAT-2:0], in_valid && (&seen_q)};
        end
    end

    // R1: reset forces the idle verdict.
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (pass && !win_done));

    // R2: the strobe never lasts two cycles.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        win_done |=> !win_done);

    // R5: the strobe appears exactly LAT edges after the closing word.
    a_r5_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
        win_done == due_q[LAT-1]);

    // R6: the flag moves only together with the strobe.
    a_r6_pass_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pass) |-> win_done);

endmodule

bind monobit_monitor monobit_monitor_chk #(
    .WIN_LOG2(WIN_LOG2),
    .LAT     (PIPE_LAT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(in_valid),
    .pass    (pass),
    .win_done(win_done)
);

// File: tb/sim_monobit_monitor.sv
// Bench: drives whole windows of patterned words, computes each window's
// ones total with $countones and predicts verdict and strobe cycle.
module sim_monobit_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 128;
    localparam int WLOG       = 8;
    localparam int NWIN       = 1 << WLOG;
    localparam int AW         = $clog2(DW * NWIN + 1);
    localparam int LAT        = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_valid = 1'b0;
    logic [AW-1:0] bound_lo = '0;
    logic [AW-1:0] bound_hi = '0;
    logic          pass;
    logic          win_done;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int last_pass = 1;
    int n_windows = 0;
    int n_dones = 0;
    bit ended = 0;
    int exp_pass_q[$];
    int exp_cyc_q[$];
    logic [31:0] seed = 32'h1234_5678;

    monobit_monitor u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_data (in_data),
        .in_valid(in_valid),
        .bound_lo(bound_lo),
        .bound_hi(bound_hi),
        .pass    (pass),
        .win_done(win_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Word generator: 0 zeros, 1 ones, 2 pseudo-random, 3 (i mod 129) low ones.
    function automatic logic [DW-1:0] make_word(input int mode, input int i, inout logic [31:0] s);
        logic [DW-1:0] w;
        int k;
        w = '0;
        case (mode)
            0: w = '0;
            1: w = '1;
            2: begin
                for (int p = 0; p < DW/32; p++) begin
                    s = s ^ (s << 13);
                    s = s ^ (s >> 17);
                    s = s ^ (s << 5);
                    w[p*32 +: 32] = s;
                end
            end
            default: begin
                k = i % 129;
                for (int b = 0; b < DW; b++) w[b] = (b < k);
            end
        endcase
        return w;
    endfunction

    function automatic int ramp_total();
        int t = 0;
        for (int i = 0; i < NWIN; i++) t += i % 129;
        return t;
    endfunction

    // Drive one window; optional invalid all-ones word after each valid one.
    task automatic send_window(input int mode, input bit gaps);
        int total = 0;
        logic [DW-1:0] w;
        for (int i = 0; i < NWIN; i++) begin
            w = make_word(mode, i, seed);
            total += $countones(w);
            in_data  = w;
            in_valid = 1'b1;
            if (i == NWIN - 1) begin
                exp_pass_q.push_back(((total > int'(bound_lo)) && (total < int'(bound_hi))) ? 1 : 0);
                exp_cyc_q.push_back(cyc + LAT);
                n_windows++;
            end
            @(negedge clk);
            if (gaps) begin
                in_data  = '1;
                in_valid = 1'b0;
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        in_data  = '0;
    endtask

    task automatic set_bounds(input int lo, input int hi);
        bound_lo = AW'(lo);
        bound_hi = AW'(hi);
    endtask

    task automatic drain();
        repeat (LAT + 4) @(negedge clk);
    endtask

    // Strobe monitor: verdict (R3), latency (R5), stability (R6).
    always @(negedge clk) begin
        if (rst_n) begin
            if (win_done) begin
                n_dones++;
                if (exp_pass_q.size() == 0) begin
                    chk(0, "R2 unexpected strobe", 1, 0);
                end else begin
                    chk(cyc == exp_cyc_q[0], "R5 strobe cycle", cyc, exp_cyc_q[0]);
                    chk(int'(pass) == exp_pass_q[0], "R3 verdict", int'(pass), exp_pass_q[0]);
                    void'(exp_pass_q.pop_front());
                    void'(exp_cyc_q.pop_front());
                end
                last_pass = int'(pass);
            end else begin
                chk(int'(pass) == last_pass, "R6 flag held", int'(pass), last_pass);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        chk(0, "R2 watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int rt;
        rt = ramp_total();

        // R1: reset state.
        repeat (3) @(negedge clk);
        chk(pass == 1'b1, "R1 pass in reset", int'(pass), 1);
        chk(win_done == 1'b0, "R1 done in reset", int'(win_done), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(pass == 1'b1 && win_done == 1'b0, "R1 idle after reset", int'(pass), 1);

        // R3: all-zero window with lower bound 0 fails (strict).
        set_bounds(0, 5);
        send_window(0, 0);
        drain();

        // R7: all-ones total held exactly.
        set_bounds(32767, 32769);
        send_window(1, 0);
        drain();
        chk(pass == 1'b1, "R7 all-ones pass", int'(pass), 1);

        // R3: bound equal to total fails on either side.
        set_bounds(32768, 40000);
        send_window(1, 0);
        drain();
        set_bounds(rt - 1, rt);
        send_window(3, 0);
        drain();
        chk(pass == 1'b0, "R3 upper bound equal", int'(pass), 0);
        set_bounds(rt - 1, rt + 1);
        send_window(3, 0);
        drain();
        chk(pass == 1'b1, "R3 exact band", int'(pass), 1);

        // R3: pseudo-random windows against the default band.
        set_bounds(monobit_pkg::band_lo(DW, WLOG, monobit_pkg::DEF_HALF_BAND),
                   monobit_pkg::band_hi(DW, WLOG, monobit_pkg::DEF_HALF_BAND));
        send_window(2, 0);
        drain();
        send_window(2, 0);
        drain();

        // R4: invalid all-ones words in between must not count.
        set_bounds(32768, 40000);
        send_window(1, 0);
        drain();
        set_bounds(rt - 1, rt + 1);
        send_window(3, 1);
        drain();
        chk(pass == 1'b1, "R4 gaps ignored", int'(pass), 1);

        // R8: back-to-back windows, total restarts at the boundary.
        send_window(1, 0);
        send_window(3, 0);
        drain();
        chk(pass == 1'b1, "R8 second window alone", int'(pass), 1);

        // R1: reset mid-window discards the partial total.
        set_bounds(32768, 40000);
        send_window(1, 0);
        drain();
        chk(pass == 1'b0, "R1 fail before reset", int'(pass), 0);
        for (int i = 0; i < 100; i++) begin
            in_data  = '1;
            in_valid = 1'b1;
            @(negedge clk);
        end
        in_valid = 1'b0;
        rst_n = 1'b0;
        last_pass = 1;
        repeat (2) @(negedge clk);
        chk(pass == 1'b1, "R1 pass after mid reset", int'(pass), 1);
        chk(win_done == 1'b0, "R1 done after mid reset", int'(win_done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        set_bounds(rt - 1, rt + 1);
        send_window(3, 0);
        drain();
        chk(pass == 1'b1, "R1 clean window after reset", int'(pass), 1);

        // R2: one strobe per window, none outstanding.
        chk(exp_pass_q.size() == 0, "R2 strobes outstanding", exp_pass_q.size(), 0);
        chk(n_dones == n_windows, "R2 strobe count", n_dones, n_windows);

        finish_run();
    end

endmodule